// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous DRAM refreshed and brings it up after reset. It first waits out a power-up pause, then issues a fixed number of wake-up refresh cycles on its own, and only then raises `init_done`. Until `init_done` is high the access controller must not use the memory.

From then on an interval timer adds one refresh to a small queue every refresh interval. While the queue is not empty and the sequencer is idle, `ref_req` is high. The access controller answers with `ref_gnt`. On a grant the sequencer takes over the RAS, CAS and WE strobes for one refresh cycle. If the grant stays high, it drains the queued refreshes back to back.

The default cycle is CAS-before-RAS, which uses the device's own row counter. With `RAS_ONLY` set, the sequencer keeps its own row counter instead, presents that row on `dram_addr`, and pulses RAS while CAS stays high. All time limits are given in nanoseconds and converted to clock cycles, rounded up, from `CLK_MHZ`. The refresh interval is the floor of the refresh window in cycles divided by the row count, 2**`ROW_W`.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is held and right after it, `dram_ras_n` and `dram_cas_n` are 1, `ref_req` is 0 and `init_done` is 0.
- R2: No strobe goes low during the power-up pause. The pause lasts ceil(PAUSE_NS*CLK_MHZ/1000) cycles after reset is released, and the first CAS fall comes within two cycles after the pause ends.
- R3: After the pause, exactly INIT_REFRESHES refresh cycles run without any grant. Each RAS fall is N_SETUP+N_ACT+N_PRE+1 cycles after the previous one. `init_done` then rises, stays high, and `ref_req` stays 0 before it.
- R4: In CAS-before-RAS mode, CAS is low for exactly N_SETUP = ceil(T_CSR_NS*CLK_MHZ/1000) cycles before RAS falls. WE stays 1 at all times.
- R5: In CAS-before-RAS mode, CAS stays low for exactly N_CHR = ceil(T_CHR_NS*CLK_MHZ/1000) cycles after RAS falls and rises while RAS is still low.
- R6: RAS is low for exactly N_ACT cycles, where N_ACT is the larger of ceil(T_RAS_NS*CLK_MHZ/1000) and N_CHR+1. Between cycles RAS is high for at least N_PRE+N_SETUP cycles, where N_PRE is the larger of the precharge time in cycles and the random cycle time in cycles minus N_ACT.
- R7: After `init_done`, one refresh is added to the queue every REFI = floor(floor(WINDOW_NS*CLK_MHZ/1000) / 2**ROW_W) cycles. With the grant held high, successive RAS falls are exactly REFI cycles apart.
- R8: `ref_req` stays high until it is granted. No refresh cycle starts after `init_done` unless `ref_gnt` was high at the edge that started it.
- R9: The queue holds at most MAX_PEND refreshes and drops any further ticks. Once granted, the queued refreshes run back to back, N_SETUP+N_ACT+N_PRE+1 cycles apart.
- R10: With RAS_ONLY=1, CAS never goes low and `dram_addr` stays stable while RAS is low. The row shown at the n-th RAS fall (counting from 0) is n mod 2**ROW_W.
- R11: With the grant held high, any 2**ROW_W+1 consecutive RAS falls span at most the refresh window in cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_gnt | input | 1 | Grant from the access controller; a refresh may start while high |
| ref_req | output | 1 | A queued refresh is waiting for the strobes |
| init_done | output | 1 | Power-up pause and wake-up cycles are complete |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, held high |
| dram_addr | output | ROW_W | Row address for RAS-only refresh; zero in CAS-before-RAS mode |

## Verification
The request-hold and granted-start assertions assume the access controller leaves `ref_gnt` alone except as a response to `ref_req`, and that it does not drive the strobes while the sequencer owns them. The bench meets this by driving the grant only at falling edges and keeping it high for long stretches. It lowers the grant for more than MAX_PEND intervals only in one phase, where the queue is made to saturate. The timing assertions assume the parameters give at least one cycle for each phase and an interval longer than one full refresh cycle. The scaled bench configuration gives 3, 13 and 10 cycle phases and a 100-cycle interval.

// File: rtl/drs_pkg.sv
// Shared types and helpers for the DRAM refresh sequencer.
// Assumes all timing arguments are non-negative nanosecond values.
package drs_pkg;

    // Phase of one refresh cycle on the DRAM strobes.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_ACTV  = 2'd2,
        PH_PRE   = 2'd3
    } phase_t;

    // Convert a time in ns to clock cycles, rounding up.
    function automatic int ns_to_cyc(longint ns, int clk_mhz);
        return int'((ns * longint'(clk_mhz) + 64'sd999) / 64'sd1000);
    endfunction

endpackage

// File: rtl/drs_tick_gen.sv
// Power-up pause counter and refresh interval timer.
// pause_done rises PAUSE_CYC cycles after reset and then stays high.
// While run is high, tick pulses once every REFI_CYC cycles.
// Assumes PAUSE_CYC >= 1 and REFI_CYC >= 2.
module drs_tick_gen #(
    parameter int PAUSE_CYC = 25000,
    parameter int REFI_CYC  = 3906
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic pause_done,
    output logic tick
);
    localparam int PW = $clog2(PAUSE_CYC + 1);
    localparam int IW = $clog2(REFI_CYC);
    localparam logic [PW-1:0] PAUSE_LIM = PW'(PAUSE_CYC);
    localparam logic [IW-1:0] REFI_LAST = IW'(REFI_CYC - 1);

    logic [PW-1:0] pause_cnt;
    logic [IW-1:0] ival_cnt;

    // Count up to the pause limit once after reset, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pause_cnt <= '0;
        else if (pause_cnt != PAUSE_LIM)
            pause_cnt <= pause_cnt + 1'b1;
    end

    // Free-running interval counter, active only while run is high.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            ival_cnt <= '0;
        else if (ival_cnt == REFI_LAST)
            ival_cnt <= '0;
        else
            ival_cnt <= ival_cnt + 1'b1;
    end

    assign pause_done = (pause_cnt == PAUSE_LIM);
    assign tick       = run && (ival_cnt == REFI_LAST);

    AST_NO_TICK_IN_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !pause_done |-> !tick); // R2

endmodule

// File: rtl/drs_pend.sv
// Saturating queue of owed refreshes.
// add puts one refresh in, take removes one. Adds made while the queue
// is full are dropped. Assumes take is raised only when has_pend is high.
module drs_pend #(
    parameter int MAX_PEND = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic add,
    input  logic take,
    output logic has_pend
);
    localparam int PCW = $clog2(MAX_PEND + 1);
    localparam logic [PCW-1:0] PEND_LIM = PCW'(MAX_PEND);

    logic [PCW-1:0] pend;

    // Track owed refreshes; an add and a take in the same cycle cancel out.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= '0;
        else if (add && !take && pend != PEND_LIM)
            pend <= pend + 1'b1;
        else if (take && !add)
            pend <= pend - 1'b1;
    end

    assign has_pend = (pend != '0);

    AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pend <= PEND_LIM); // R9
    AST_TAKE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> pend != '0); // R9

endmodule

// File: rtl/drs_cycle_fsm.sv
// Runs one refresh cycle per start pulse: setup, RAS active, precharge.
// CAS-before-RAS variant: CAS falls at setup and rises N_CHR cycles
// into the active phase. RAS-only variant: CAS stays high and an
// internal row counter is driven on row_addr, advancing after each cycle.
// start is ignored unless the sequencer is idle. Assumes every phase
// length is >= 1 and N_CHR < N_ACT.
module drs_cycle_fsm
    import drs_pkg::*;
#(
    parameter int ROW_W    = 10,
    parameter int N_SETUP  = 3,
    parameter int N_CHR    = 3,
    parameter int N_ACT    = 13,
    parameter int N_PRE    = 10,
    parameter bit RAS_ONLY = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic [ROW_W-1:0] row_addr
);
    localparam int N_MAX1  = (N_SETUP > N_ACT) ? N_SETUP : N_ACT;
    localparam int N_MAX   = (N_MAX1 > N_PRE) ? N_MAX1 : N_PRE;
    localparam int CW      = $clog2(N_MAX + 1);
    localparam int RW      = $clog2(2 * N_MAX + 2);
    localparam logic [RW-1:0] RUN_SAT = {RW{1'b1}};

    phase_t        phase;
    logic [CW-1:0] cnt;
    logic [CW-1:0] last;
    logic          at_end;
    logic [RW-1:0] low_run;
    logic [RW-1:0] high_run;

    // Last count value of the current phase.
    always_comb begin
        case (phase)
            PH_SETUP: last = CW'(N_SETUP - 1);
            PH_ACTV:  last = CW'(N_ACT - 1);
            PH_PRE:   last = CW'(N_PRE - 1);
            default:  last = '0;
        endcase
    end

    assign at_end = (cnt == last);

    // Step through the phases of one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    cnt <= '0;
                    if (start)
                        phase <= PH_SETUP;
                end
                PH_SETUP: begin
                    cnt <= at_end ? '0 : cnt + 1'b1;
                    if (at_end)
                        phase <= PH_ACTV;
                end
                PH_ACTV: begin
                    cnt <= at_end ? '0 : cnt + 1'b1;
                    if (at_end)
                        phase <= PH_PRE;
                end
                default: begin
                    cnt <= at_end ? '0 : cnt + 1'b1;
                    if (at_end)
                        phase <= PH_IDLE;
                end
            endcase
        end
    end

    assign busy  = (phase != PH_IDLE);
    assign done  = (phase == PH_PRE) && at_end;
    assign ras_n = (phase != PH_ACTV);
    assign we_n  = 1'b1;

    generate
        if (RAS_ONLY) begin : g_ras_only
            logic [ROW_W-1:0] row;

            // Advance the own row counter after each finished cycle.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    row <= '0;
                else if (done)
                    row <= row + 1'b1;
            end

            assign cas_n    = 1'b1;
            assign row_addr = row;

            AST_RO_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
                !ras_n |-> $stable(row_addr)); // R10
        end else begin : g_cbr
            logic cas_low;

            // CAS leads RAS in setup and is held for N_CHR cycles after.
            assign cas_low  = (phase == PH_SETUP) ||
                              ((phase == PH_ACTV) && (cnt < CW'(N_CHR)));
            assign cas_n    = !cas_low;
            assign row_addr = '0;

            AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(ras_n) |-> (!cas_n && $past(!cas_n))); // R4
            AST_CAS_RISES_IN_ACT: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(cas_n) |-> !ras_n); // R5
        end
    endgenerate

    // Length of the current RAS low run, used only by the checks below.
    always_ff @(posedge clk) begin
        if (!rst_n || ras_n)
            low_run <= '0;
        else if (low_run != RUN_SAT)
            low_run <= low_run + 1'b1;
    end

    // Length of the current RAS high run, used only by the checks below.
    always_ff @(posedge clk) begin
        if (!rst_n || !ras_n)
            high_run <= '0;
        else if (high_run != RUN_SAT)
            high_run <= high_run + 1'b1;
    end

    AST_RAS_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> low_run >= RW'(N_ACT)); // R6
    AST_RAS_MIN_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> high_run >= RW'(N_PRE)); // R6

endmodule

// File: rtl/dram_refresh_seq.sv
// DRAM refresh and power-up sequencer.
// After reset it waits the power-up pause, runs INIT_REFRESHES wake-up
// refresh cycles, then raises init_done. After that, each interval tick
// queues one refresh. The queue is drained through a req/gnt handshake
// with the access controller, which must leave the strobes to this
// block while a cycle is in progress.
module dram_refresh_seq
    import drs_pkg::*;
#(
    parameter int CLK_MHZ        = 250,
    parameter int ROW_W          = 10,
    parameter int WINDOW_NS      = 16000000,
    parameter int PAUSE_NS       = 100000,
    parameter int INIT_REFRESHES = 8,
    parameter int MAX_PEND       = 4,
    parameter int T_CSR_NS       = 10,
    parameter int T_CHR_NS       = 10,
    parameter int T_RAS_NS       = 50,
    parameter int T_RP_NS        = 30,
    parameter int T_RC_NS        = 90,
    parameter bit RAS_ONLY       = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_gnt,
    output logic             ref_req,
    output logic             init_done,
    output logic             dram_ras_n,
    output logic             dram_cas_n,
    output logic             dram_we_n,
    output logic [ROW_W-1:0] dram_addr
);
    localparam longint WIN_CYC  = (longint'(WINDOW_NS) * longint'(CLK_MHZ)) / 64'sd1000;
    localparam int REFI_CYC     = int'(WIN_CYC >> ROW_W);
    localparam int PAUSE_CYC    = ns_to_cyc(longint'(PAUSE_NS), CLK_MHZ);
    localparam int N_SETUP      = ns_to_cyc(longint'(T_CSR_NS), CLK_MHZ);
    localparam int N_CHR        = ns_to_cyc(longint'(T_CHR_NS), CLK_MHZ);
    localparam int N_RAS_RAW    = ns_to_cyc(longint'(T_RAS_NS), CLK_MHZ);
    localparam int N_ACT        = (N_RAS_RAW > N_CHR) ? N_RAS_RAW : N_CHR + 1;
    localparam int N_RP_RAW     = ns_to_cyc(longint'(T_RP_NS), CLK_MHZ);
    localparam int N_RC_REST    = ns_to_cyc(longint'(T_RC_NS), CLK_MHZ) - N_ACT;
    localparam int N_PRE        = (N_RP_RAW > N_RC_REST) ? N_RP_RAW : N_RC_REST;
    localparam int ICW          = $clog2(INIT_REFRESHES + 1);
    localparam logic [ICW-1:0] INIT_LIM = ICW'(INIT_REFRESHES);

    logic           pause_done;
    logic           tick;
    logic           has_pend;
    logic           busy;
    logic           done;
    logic           init_start;
    logic           norm_start;
    logic [ICW-1:0] init_cnt;

    drs_tick_gen #(
        .PAUSE_CYC (PAUSE_CYC),
        .REFI_CYC  (REFI_CYC)
    ) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (init_done),
        .pause_done (pause_done),
        .tick       (tick)
    );

    drs_pend #(
        .MAX_PEND (MAX_PEND)
    ) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .add      (tick),
        .take     (norm_start),
        .has_pend (has_pend)
    );

    drs_cycle_fsm #(
        .ROW_W    (ROW_W),
        .N_SETUP  (N_SETUP),
        .N_CHR    (N_CHR),
        .N_ACT    (N_ACT),
        .N_PRE    (N_PRE),
        .RAS_ONLY (RAS_ONLY)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (init_start || norm_start),
        .busy     (busy),
        .done     (done),
        .ras_n    (dram_ras_n),
        .cas_n    (dram_cas_n),
        .we_n     (dram_we_n),
        .row_addr (dram_addr)
    );

    // Count finished wake-up cycles until the required number is reached.
    always_ff @(posedge clk) begin
        if (!rst_n)
            init_cnt <= '0;
        else if (done && !init_done)
            init_cnt <= init_cnt + 1'b1;
    end

    assign init_done  = (init_cnt == INIT_LIM);
    assign init_start = pause_done && !init_done && !busy;
    assign ref_req    = init_done && !busy && has_pend;
    assign norm_start = ref_req && ref_gnt;

    AST_IDLE_IN_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !pause_done |-> (dram_ras_n && dram_cas_n)); // R2
    AST_INIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done); // R3
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !ref_gnt) |=> ref_req); // R8
    AST_GRANTED_START: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && $past(init_done)) |-> $past(ref_gnt)); // R8

endmodule

// File: tb/dram_refresh_seq_tb.sv
// Bench for the refresh sequencer in a scaled configuration: 16 rows,
// a 6400 ns window, a 2000 ns pause. It sweeps every refresh cycle
// seen and checks strobe timing against values computed from the
// requirements.
module dram_refresh_seq_tb;
    localparam int CLK_MHZ   = 250;
    localparam int ROW_W     = 4;
    localparam int ROWS      = 1 << ROW_W;
    localparam int WINDOW_NS = 6400;
    localparam int PAUSE_NS  = 2000;
    localparam int MAX_PEND  = 3;
    localparam int INIT_N    = 8;

    localparam int PAUSE_CYC = (PAUSE_NS * CLK_MHZ + 999) / 1000;
    localparam int WIN_CYC   = (WINDOW_NS * CLK_MHZ) / 1000;
    localparam int REFI      = WIN_CYC / ROWS;
    localparam int N_SETUP   = (10 * CLK_MHZ + 999) / 1000;
    localparam int N_CHR     = (10 * CLK_MHZ + 999) / 1000;
    localparam int N_ACT_R   = (50 * CLK_MHZ + 999) / 1000;
    localparam int N_ACT     = (N_ACT_R > N_CHR) ? N_ACT_R : N_CHR + 1;
    localparam int N_RP      = (30 * CLK_MHZ + 999) / 1000;
    localparam int N_RCR     = (90 * CLK_MHZ + 999) / 1000 - N_ACT;
    localparam int N_PRE     = (N_RP > N_RCR) ? N_RP : N_RCR;
    localparam int SPACING   = N_SETUP + N_ACT + N_PRE + 1;

    logic clk = 1'b0;
    logic rst_n;
    logic gnt;
    logic req, idone, ras_n, cas_n, we_n;
    logic [ROW_W-1:0] addr;
    logic ro_req, ro_idone, ro_ras_n, ro_cas_n, ro_we_n;
    logic [ROW_W-1:0] ro_addr;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dram_refresh_seq #(
        .CLK_MHZ(CLK_MHZ), .ROW_W(ROW_W), .WINDOW_NS(WINDOW_NS),
        .PAUSE_NS(PAUSE_NS), .INIT_REFRESHES(INIT_N), .MAX_PEND(MAX_PEND),
        .RAS_ONLY(1'b0)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_gnt(gnt), .ref_req(req),
        .init_done(idone), .dram_ras_n(ras_n), .dram_cas_n(cas_n),
        .dram_we_n(we_n), .dram_addr(addr)
    );

    dram_refresh_seq #(
        .CLK_MHZ(CLK_MHZ), .ROW_W(ROW_W), .WINDOW_NS(WINDOW_NS),
        .PAUSE_NS(PAUSE_NS), .INIT_REFRESHES(INIT_N), .MAX_PEND(MAX_PEND),
        .RAS_ONLY(1'b1)
    ) u_dut_ro (
        .clk(clk), .rst_n(rst_n), .ref_gnt(1'b1), .ref_req(ro_req),
        .init_done(ro_idone), .dram_ras_n(ro_ras_n), .dram_cas_n(ro_cas_n),
        .dram_we_n(ro_we_n), .dram_addr(ro_addr)
    );

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", rq, cyc, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // Monitor state for the CAS-before-RAS instance.
    int fall_t [0:511];
    int nfall = 0;
    int first_act = -1;
    int cas_low_run = 0, ras_low_run = 0, ras_high_run = 0, chr_run = 0;
    int we_bad = 0, req_pre_init = 0;
    logic p_ras = 1'b1, p_cas = 1'b1;
    // Monitor state for the RAS-only instance.
    int ro_nfall = 0, ro_cas_low = 0;
    logic p_ro_ras = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (first_act < 0 && (!ras_n || !cas_n)) first_act = cyc;
            if (!we_n || !ro_we_n) we_bad++;
            if (req && !idone) req_pre_init++;
            if (!ras_n && p_ras) begin
                check(cas_low_run == N_SETUP, "R4 CAS lead", cas_low_run, N_SETUP);
                if (nfall > 0)
                    check(ras_high_run >= N_PRE + N_SETUP, "R6 precharge", ras_high_run, N_PRE + N_SETUP);
                if (nfall < 512) fall_t[nfall] = cyc;
                nfall++;
                chr_run = 0;
            end
            if (ras_n && !p_ras)
                check(ras_low_run == N_ACT, "R6 RAS low", ras_low_run, N_ACT);
            if (cas_n && !p_cas && !ras_n)
                check(chr_run == N_CHR, "R5 CAS hold", chr_run, N_CHR);
            if (!ras_n && !cas_n) chr_run++;
            cas_low_run  = cas_n ? 0 : cas_low_run + 1;
            ras_low_run  = ras_n ? 0 : ras_low_run + 1;
            ras_high_run = ras_n ? ras_high_run + 1 : 0;
            p_ras = ras_n;
            p_cas = cas_n;
            if (!ro_cas_n) ro_cas_low++;
            if (!ro_ras_n && p_ro_ras) begin
                check(int'(ro_addr) == ro_nfall % ROWS, "R10 row address", int'(ro_addr), ro_nfall % ROWS);
                ro_nfall++;
            end
            p_ro_ras = ro_ras_n;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int idx0, n0, n1, n2, req_low;
        rst_n = 1'b0;
        gnt   = 1'b1;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(ras_n == 1'b1 && cas_n == 1'b1, "R1 strobes", {ras_n, cas_n}, 3);
        check(req == 1'b0 && idone == 1'b0, "R1 req/init", {req, idone}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ras_n && cas_n && !req && !idone, "R1 after release", {ras_n, cas_n, req, idone}, 12);

        while (!idone) @(negedge clk);
        // R2: pause
        check(first_act >= PAUSE_CYC && first_act <= PAUSE_CYC + 2, "R2 pause end", first_act, PAUSE_CYC + 1);
        // R3: wake-up cycles
        check(nfall == INIT_N, "R3 wake-up count", nfall, INIT_N);
        for (int i = 1; i < INIT_N && i < nfall; i++)
            check(fall_t[i] - fall_t[i-1] == SPACING, "R3 wake-up spacing", fall_t[i] - fall_t[i-1], SPACING);
        check(req_pre_init == 0, "R3 no req before init", req_pre_init, 0);

        // R7, R11: steady refresh with grant held high
        idx0 = nfall;
        repeat (3 * WIN_CYC) @(negedge clk);
        for (int i = idx0; i + 1 < nfall; i++)
            check(fall_t[i+1] - fall_t[i] == REFI, "R7 interval", fall_t[i+1] - fall_t[i], REFI);
        for (int i = idx0; i + ROWS < nfall; i++)
            check(fall_t[i+ROWS] - fall_t[i] <= WIN_CYC, "R11 window", fall_t[i+ROWS] - fall_t[i], WIN_CYC);
        check(nfall - idx0 >= 2 * ROWS, "R11 refresh count", nfall - idx0, 2 * ROWS);

        // R8: withhold the grant; the request must stay up, no cycles start
        gnt = 1'b0;
        repeat (SPACING + 3) @(negedge clk);
        n0 = nfall;
        req_low = 0;
        repeat (REFI + 10) @(negedge clk);
        for (int i = 0; i < 8 * REFI; i++) begin
            @(negedge clk);
            if (!req) req_low++;
        end
        check(req_low == 0, "R8 request held", req_low, 0);
        check(nfall == n0, "R8 no cycle without grant", nfall - n0, 0);

        // R9: grant again; exactly MAX_PEND cycles back to back
        gnt = 1'b1;
        n1 = nfall;
        repeat (MAX_PEND * SPACING) @(negedge clk);
        check(nfall - n1 == MAX_PEND, "R9 queued drain", nfall - n1, MAX_PEND);
        for (int i = n1 + 1; i < nfall; i++)
            check(fall_t[i] - fall_t[i-1] == SPACING, "R9 back to back", fall_t[i] - fall_t[i-1], SPACING);
        n2 = nfall;
        repeat (REFI) @(negedge clk);
        check(nfall - n2 <= 2, "R9 overflow dropped", nfall - n2, 2);

        // R4: WE never low; R10: RAS-only instance never drops CAS
        check(we_bad == 0, "R4 WE high", we_bad, 0);
        check(ro_cas_low == 0, "R10 CAS high", ro_cas_low, 0);
        check(ro_nfall >= INIT_N + ROWS, "R10 RAS-only cycles", ro_nfall, INIT_N + ROWS);
        finish_run();
    end

endmodule